// File: doc/BRIEF.md
# Accumulator Machine Micro-Step Sequencer

This block is a small accumulator computer built around a single shared byte bus. A 16-word memory, an instruction register, a program counter, an accumulator and a four-function ALU are tied to that bus. A sequencer walks every instruction through fixed micro-steps. On each step it enables at most one bus source, and any number of registers may capture the bus on the same edge. Once an instruction finishes, the sequencer goes back to fetching the next one. A HALT instruction parks the machine until reset.

The memory image is taken from a parameter while reset is asserted, so one instance carries its own program and data. The accumulator, its zero flag, the halt status, the program counter, the instruction register, the bus value, the driver-enable vector and the memory write strobe are brought out so that the sequence can be followed and bus contention can be checked from outside.

Top module: `acc_seq_top`

## Requirements
- R1: While `rst_n` is low, the program counter and accumulator read 0, `halted_o` is 0, memory holds the `PROG` image with word i in bits [8i+7:8i], and the first step after release is a fetch.
- R2: An instruction is 8 bits, with the opcode in bits [7:4] and the address in bits [3:0]. Fetch takes two cycles. In the first, memory drives `mem[pc]` onto the bus (`drv_en_o` = 01) and the instruction register loads it. In the second, no source drives and the program counter advances by 1 modulo 16.
- R3: LOAD (opcode 1): memory drives `mem[addr]` onto the bus (`drv_en_o` = 01) and the accumulator loads that byte.
- R4: ADD (opcode 2) and SUB (opcode 4): memory drives `mem[addr]`, and the accumulator becomes the accumulator plus or minus that byte, modulo 256.
- R5: CLR (opcode 5): no source drives and the accumulator becomes 0.
- R6: STORE (opcode 3): the accumulator is the only source driving (`drv_en_o` = 10), `mem_we_o` is high, and `mem[addr]` takes the accumulator value.
- R7: HALT (opcode F): no source drives. From the next cycle `halted_o` is 1 and the program counter, accumulator and memory stay frozen until reset.
- R8: Opcodes 0 and 6 to E take one execute cycle with no driver, no write and no register change.
- R9: `drv_en_o` is zero or one-hot on every cycle. Bit 0 is memory and bit 1 is the accumulator. `bus_o` carries the enabled source's value, or 0 when none is enabled.
- R10: The instruction register does not change between the end of fetch and the end of execute.
- R11: `zero_o` is 1 exactly when the accumulator is 0.
- R12: Every execute phase lasts one cycle and is followed by a fetch, so each instruction other than HALT takes three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_o | output | DW | Accumulator |
| zero_o | output | 1 | Accumulator equals zero |
| halted_o | output | 1 | Machine is parked after HALT |
| pc_o | output | AW | Program counter |
| ir_o | output | DW | Instruction register |
| bus_o | output | DW | Shared bus value |
| drv_en_o | output | 2 | Bus source enables (bit 0 memory, bit 1 accumulator) |
| mem_we_o | output | 1 | Memory write strobe |

## Verification
The assertions assume that reset is released away from a clock edge and that the memory image is fixed by the parameter, because the block has no other input. The bench drives reset only at falling edges. It runs a single program that walks clear, add 5, add 10, store, subtract 15 and reload, then continues through wrapping add and subtract, two unknown opcodes, a second store and HALT. This keeps every step inside the defined opcode set or the no-operation range.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW  = 4;
  localparam int NSRC = 2;
  localparam int SRC_MEM = 0;
  localparam int SRC_ACC = 1;

  localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPW-1:0] OP_ADD   = 4'h2;
  localparam logic [OPW-1:0] OP_STORE = 4'h3;
  localparam logic [OPW-1:0] OP_SUB   = 4'h4;
  localparam logic [OPW-1:0] OP_CLR   = 4'h5;
  localparam logic [OPW-1:0] OP_HALT  = 4'hF;

  typedef enum logic [1:0] {
    ST_FETCH_A = 2'd0,
    ST_FETCH_B = 2'd1,
    ST_EXEC    = 2'd2,
    ST_HALT    = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    FN_CLR  = 2'd0,
    FN_ADD  = 2'd1,
    FN_SUB  = 2'd2,
    FN_PASS = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic [NSRC-1:0] drv_en;
    logic            ir_ld;
    logic            pc_inc;
    logic            acc_ld;
    alu_fn_e         alu_fn;
    logic            mem_we;
    logic            addr_ir;
  } ctrl_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  acc_pkg::alu_fn_e fn,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [DW-1:0]    y
);
  import acc_pkg::*;

  always_comb begin
    unique case (fn)
      FN_CLR:  y = '0;
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW,
  parameter logic [DW*DEPTH-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic wr_en;
      assign wr_en = we && (addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mem_q[i] <= INIT[i*DW +: DW];
        else if (wr_en) mem_q[i] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem_q[addr];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [acc_pkg::OPW-1:0] opcode,
  output acc_pkg::ctrl_t        ctrl,
  output acc_pkg::step_e        step
);
  import acc_pkg::*;

  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_FETCH_A: step_d = ST_FETCH_B;
      ST_FETCH_B: step_d = ST_EXEC;
      ST_EXEC:    step_d = (opcode == OP_HALT) ? ST_HALT : ST_FETCH_A;
      default:    step_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH_A;
    else        step_q <= step_d;
  end

  always_comb begin
    ctrl = '{drv_en: '0, ir_ld: 1'b0, pc_inc: 1'b0, acc_ld: 1'b0,
             alu_fn: FN_PASS, mem_we: 1'b0, addr_ir: 1'b0};
    unique case (step_q)
      ST_FETCH_A: begin
        ctrl.drv_en[SRC_MEM] = 1'b1;
        ctrl.ir_ld           = 1'b1;
      end
      ST_FETCH_B: ctrl.pc_inc = 1'b1;
      ST_EXEC: begin
        ctrl.addr_ir = 1'b1;
        unique case (opcode)
          OP_LOAD, OP_ADD, OP_SUB: begin
            ctrl.drv_en[SRC_MEM] = 1'b1;
            ctrl.acc_ld          = 1'b1;
            ctrl.alu_fn = (opcode == OP_ADD) ? FN_ADD :
                          (opcode == OP_SUB) ? FN_SUB : FN_PASS;
          end
          OP_CLR: begin
            ctrl.acc_ld = 1'b1;
            ctrl.alu_fn = FN_CLR;
          end
          OP_STORE: begin
            ctrl.drv_en[SRC_ACC] = 1'b1;
            ctrl.mem_we          = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign step = step_q;
endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW,
  parameter logic [DW*DEPTH-1:0] PROG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] acc_o,
  output logic          zero_o,
  output logic          halted_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] bus_o,
  output logic [1:0]    drv_en_o,
  output logic          mem_we_o
);
  import acc_pkg::*;

  ctrl_t         ctrl;
  step_e         step;
  logic [AW-1:0] pc_q, pc_d, mem_addr;
  logic [DW-1:0] ir_q, ir_d, acc_q, acc_d, alu_y, mem_rd, bus;
  logic [DW-1:0] src [NSRC];

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir_q[DW-1 -: OPW]),
    .ctrl   (ctrl),
    .step   (step)
  );

  assign mem_addr = ctrl.addr_ir ? ir_q[AW-1:0] : pc_q;

  acc_mem #(.DW(DW), .AW(AW), .INIT(PROG)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (mem_addr),
    .we    (ctrl.mem_we),
    .wdata (bus),
    .rdata (mem_rd)
  );

  assign src[SRC_MEM] = mem_rd;
  assign src[SRC_ACC] = acc_q;

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (ctrl.drv_en[i]) bus = bus | src[i];
    end
  end

  acc_alu #(.DW(DW)) u_alu (
    .fn (ctrl.alu_fn),
    .a  (acc_q),
    .b  (bus),
    .y  (alu_y)
  );

  always_comb begin
    pc_d  = ctrl.pc_inc ? pc_q + 1'b1 : pc_q;
    ir_d  = ctrl.ir_ld  ? bus : ir_q;
    acc_d = ctrl.acc_ld ? alu_y : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      acc_q <= acc_d;
    end
  end

  assign acc_o    = acc_q;
  assign zero_o   = (acc_q == '0);
  assign halted_o = (step == ST_HALT);
  assign pc_o     = pc_q;
  assign ir_o     = ir_q;
  assign bus_o    = bus;
  assign drv_en_o = ctrl.drv_en;
  assign mem_we_o = ctrl.mem_we;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    drv_en,
  input logic          mem_we,
  input logic [DW-1:0] ir,
  input logic [AW-1:0] pc,
  input logic          halted,
  input logic [DW-1:0] acc
);
  // R9: never two bus sources at once
  a_r9_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_en));

  // R6: a write step lets only the accumulator drive
  a_r6_store_excl: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (drv_en == 2'b10));

  // R10: instruction register holds across execute
  a_r10_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |=> $stable(ir));

  // R7: parked machine stays frozen
  a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(acc)));

  // R2: program counter only steps by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> (pc == AW'($past(pc) + 1'b1)));
endmodule

bind acc_seq_top acc_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .drv_en (drv_en_o),
  .mem_we (mem_we_o),
  .ir     (ir_o),
  .pc     (pc_o),
  .halted (halted_o),
  .acc    (acc_o)
);

// File: tb/acc_seq_top_test.sv
`timescale 1ns/1ps
module acc_seq_top_test;
  localparam logic [127:0] IMG = 128'h000A05F5_FF3E4C7A_002C1F4F_3F2E2D50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_o, ir_o, bus_o;
  logic [3:0] pc_o;
  logic [1:0] drv_en_o;
  logic       zero_o, halted_o, mem_we_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  acc_seq_top #(.DW(8), .AW(4), .PROG(IMG)) uut (
    .clk(clk), .rst_n(rst_n), .acc_o(acc_o), .zero_o(zero_o),
    .halted_o(halted_o), .pc_o(pc_o), .ir_o(ir_o), .bus_o(bus_o),
    .drv_en_o(drv_en_o), .mem_we_o(mem_we_o)
  );

  // behavioural reference
  int m_mem [16];
  int m_phase, m_pc, m_ir, m_acc;

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_mem[i] = int'(IMG[i*8 +: 8]);
    m_phase = 0; m_pc = 0; m_ir = 0; m_acc = 0;
  endtask

  task automatic model_step();
    int op, ad;
    op = m_ir >> 4; ad = m_ir & 15;
    case (m_phase)
      0: begin m_ir = m_mem[m_pc]; m_phase = 1; end
      1: begin m_pc = (m_pc + 1) % 16; m_phase = 2; end
      2: begin
        case (op)
          1: m_acc = m_mem[ad];
          2: m_acc = (m_acc + m_mem[ad]) % 256;
          4: m_acc = (m_acc - m_mem[ad] + 256) % 256;
          5: m_acc = 0;
          3: m_mem[ad] = m_acc;
          default: ;
        endcase
        m_phase = (op == 15) ? 3 : 0;
      end
      default: ;
    endcase
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int op, ad, e_drv, e_bus, e_we;
    string tag;
    op = m_ir >> 4; ad = m_ir & 15;
    e_drv = 0; e_bus = 0; e_we = 0; tag = "R12 fetch";
    if (m_phase == 0) begin e_drv = 1; e_bus = m_mem[m_pc]; tag = "R2 fetch"; end
    else if (m_phase == 2) begin
      case (op)
        1: begin e_drv = 1; e_bus = m_mem[ad]; tag = "R3 load"; end
        2, 4: begin e_drv = 1; e_bus = m_mem[ad]; tag = "R4 add/sub"; end
        3: begin e_drv = 2; e_bus = m_acc; e_we = 1; tag = "R6 store"; end
        5: tag = "R5 clear";
        15: tag = "R7 halt step";
        default: tag = "R8 unknown opcode";
      endcase
    end else if (m_phase == 3) tag = "R7 halted";
    check({tag, " drv_en (R9)"}, int'(drv_en_o), e_drv);
    check({tag, " bus (R9)"}, int'(bus_o), e_bus);
    check({tag, " mem_we"}, int'(mem_we_o), e_we);
    check({tag, " acc"}, int'(acc_o), m_acc);
    check({tag, " pc"}, int'(pc_o), m_pc);
    check("R11 zero flag", int'(zero_o), (m_acc == 0) ? 1 : 0);
    check("R7 halted_o", int'(halted_o), (m_phase == 3) ? 1 : 0);
    if (m_phase == 2) check("R10 ir held in execute", int'(ir_o), m_ir);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit saw_zero_mid;
    saw_zero_mid = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset acc", int'(acc_o), 0);
    check("R1 reset pc", int'(pc_o), 0);
    check("R1 reset halted", int'(halted_o), 0);
    check("R11 zero in reset", int'(zero_o), 1);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 60; cyc++) begin
      compare_all();
      if (m_phase == 2 && (m_ir >> 4) == 4 && m_acc == 15) saw_zero_mid = 1;
      @(posedge clk);
      model_step();
      @(negedge clk);
    end
    check("R4 subtract 15 reached", int'(saw_zero_mid), 1);
    check("R7 final halted", int'(halted_o), 1);
    check("R7 final acc", int'(acc_o), 15);
    check("R12 final pc after halt", int'(pc_o), 12);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule